// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the register-transfer datapath of a small multicycle processor. It holds the program counter, the instruction register, a 32-entry register file and four step registers. `A` and `B` hold the source operands. `S` holds the ALU result and `M` holds data read from memory. Around these sit the ALU, the immediate extender and the operand and write-back selectors. Each clock cycle performs one short step: fetch, operand read, execute, memory access or write-back. A separate controller sequences an instruction over several such cycles.

The controller drives discrete enable and select inputs and reads back the opcode field and an equality flag. One unified memory port carries instructions and data. The port has a word address taken from either the PC or `S`, a write enable, write data taken from `B`, and read data. The datapath supports these instruction forms:

- register-register arithmetic and logic
- OR with an immediate
- load word
- store word
- branch if equal

Top module: `mc_datapath`

## Requirements
- R1: After reset the PC is 0 and every register-file entry and step register is 0.
- R2: `mem_addr` is PC[31:2] when `addr_sel` is 0 and S[31:2] when it is 1. With `ir_ld` high, the instruction register loads `mem_rdata` at the next clock edge.
- R3: With `ab_ld` high, A loads register rs (instruction bits 25:21) and B loads register rt (bits 20:16).
- R4: With `s_ld` high, S loads the ALU result. The second operand is B when `alu_src_imm`=0 and the extended immediate when it is 1. `alu_op` selects the operation: 00 add, 01 subtract, 10 OR, 11 decode by the function field (bits 5:0). The function-field codes are 0x20/0x21 add, 0x22/0x23 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than; any other code adds.
- R5: The immediate (bits 15:0) is sign-extended when `ext_sign`=1 and zero-extended when `ext_sign`=0.
- R6: With `m_ld` high, M loads `mem_rdata`. With `rf_wr` high, the register file writes M when `wb_sel`=1 and S when `wb_sel`=0. The destination is rd (bits 15:11) when `dst_rd`=1 and rt when `dst_rd`=0.
- R7: `mem_wdata` is B, and `mem_we` follows `st_en`, so a store writes B at word address S[31:2].
- R8: `equal` is 1 exactly when A equals B.
- R9: With `pc_ld` high, the PC becomes PC+4, plus the sign-extended immediate shifted left by two when `pc_br` is 1. With `pc_ld` low the PC holds.
- R10: Register 0 always reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_ld | input | 1 | Load instruction register |
| ab_ld | input | 1 | Load A and B from the register file |
| s_ld | input | 1 | Load S with the ALU result |
| m_ld | input | 1 | Load M with memory read data |
| rf_wr | input | 1 | Register file write |
| pc_ld | input | 1 | Update PC |
| pc_br | input | 1 | Add branch offset on PC update |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 S |
| alu_src_imm | input | 1 | ALU second operand: 0 B, 1 immediate |
| ext_sign | input | 1 | Immediate extension: 1 sign, 0 zero |
| alu_op | input | 2 | ALU operation select |
| wb_sel | input | 1 | Write-back source: 0 S, 1 M |
| dst_rd | input | 1 | Destination: 1 rd, 0 rt |
| st_en | input | 1 | Store request |
| opcode | output | 6 | Instruction bits 31:26 |
| equal | output | 1 | A equals B |
| mem_addr | output | 30 | Word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |

## Verification
A wrong ALU, extension or destination choice leaves a bad value in the register file. That value cannot be seen at the ports until it is read into B. The bench therefore reads back the target register with a probe instruction, which fetches and decodes it, within two cycles of each write-back. A corrupted PC shows on `mem_addr` on the next fetch, and at the latest in the end-of-run PC check. A wrong branch decision or offset shifts every later fetch address. A bad A or B shows on `equal` and `mem_wdata` in the cycle after decode.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_ld,
  input  logic            ab_ld,
  input  logic            s_ld,
  input  logic            m_ld,
  input  logic            rf_wr,
  input  logic            pc_ld,
  input  logic            pc_br,
  input  logic            addr_sel,
  input  logic            alu_src_imm,
  input  logic            ext_sign,
  input  logic [1:0]      alu_op,
  input  logic            wb_sel,
  input  logic            dst_rd,
  input  logic            st_en,
  output logic [5:0]      opcode,
  output logic            equal,
  output logic [XLEN-3:0] mem_addr,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);
  localparam int RW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, s_q, m_q;
  logic [XLEN-1:0] rf [NREG];
  logic [XLEN-1:0] imm_x, opnd, alu_y, wb_val, rd_a, rd_b, br_off;
  logic [RW-1:0]   rs_f, rt_f, rd_f, dst;
  logic [5:0]      fn;

  assign opcode = ir_q[31:26];
  assign rs_f   = ir_q[25:21];
  assign rt_f   = ir_q[20:16];
  assign rd_f   = ir_q[15:11];
  assign fn     = ir_q[5:0];

  assign imm_x  = ext_sign ? {{(XLEN-16){ir_q[15]}}, ir_q[15:0]} : {{(XLEN-16){1'b0}}, ir_q[15:0]};
  assign br_off = {{(XLEN-18){ir_q[15]}}, ir_q[15:0], 2'b00};
  assign opnd   = alu_src_imm ? imm_x : b_q;

  always_comb begin
    case (alu_op)
      2'b00: alu_y = a_q + opnd;
      2'b01: alu_y = a_q - opnd;
      2'b10: alu_y = a_q | opnd;
      default: begin
        case (fn)
          6'h22, 6'h23: alu_y = a_q - opnd;
          6'h24:        alu_y = a_q & opnd;
          6'h25:        alu_y = a_q | opnd;
          6'h2A:        alu_y = {{(XLEN-1){1'b0}}, $signed(a_q) < $signed(opnd)};
          default:      alu_y = a_q + opnd;
        endcase
      end
    endcase
  end

  assign rd_a   = (rs_f == '0) ? '0 : rf[rs_f];
  assign rd_b   = (rt_f == '0) ? '0 : rf[rt_f];
  assign dst    = dst_rd ? rd_f : rt_f;
  assign wb_val = wb_sel ? m_q : s_q;

  assign equal     = (a_q == b_q);
  assign mem_addr  = addr_sel ? s_q[XLEN-1:2] : pc_q[XLEN-1:2];
  assign mem_we    = st_en;
  assign mem_wdata = b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0; ir_q <= '0; a_q <= '0; b_q <= '0; s_q <= '0; m_q <= '0;
    end else begin
      if (pc_ld)  pc_q <= pc_q + 4 + (pc_br ? br_off : '0);
      if (ir_ld)  ir_q <= mem_rdata;
      if (ab_ld) begin a_q <= rd_a; b_q <= rd_b; end
      if (s_ld)   s_q <= alu_y;
      if (m_ld)   m_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (rf_wr && dst != '0) begin
      rf[dst] <= wb_val;
    end
  end

  AST_PC_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !pc_ld |=> $stable(pc_q)); // R9
  AST_PC_SEQ:   assert property (@(posedge clk) disable iff (!rst_n) (pc_ld && !pc_br) |=> pc_q == $past(pc_q) + 4); // R9
  AST_IR_LOAD:  assert property (@(posedge clk) disable iff (!rst_n) ir_ld |=> ir_q == $past(mem_rdata)); // R2
  AST_A_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (ab_ld && rs_f == '0) |=> a_q == '0); // R10
  AST_S_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !s_ld |=> $stable(s_q)); // R4
  AST_ORI_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ld && alu_src_imm && !ext_sign && alu_op == 2'b10) |=> s_q[XLEN-1:16] == $past(a_q[XLEN-1:16])); // R5
  AST_M_LOAD:   assert property (@(posedge clk) disable iff (!rst_n) m_ld |=> m_q == $past(mem_rdata)); // R6
endmodule

// File: tb/mc_datapath_tb.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_ld, ab_ld, s_ld, m_ld, rf_wr, pc_ld, pc_br, addr_sel, alu_src_imm, ext_sign, wb_sel, dst_rd, st_en;
  logic [1:0]  alu_op;
  logic [5:0]  opcode;
  logic        equal, mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [256];
  int errors = 0;
  int checks = 0;
  logic [31:0] exp_pc = 0;

  always #4 clk = ~clk;

  mc_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .ir_ld(ir_ld), .ab_ld(ab_ld), .s_ld(s_ld), .m_ld(m_ld),
    .rf_wr(rf_wr), .pc_ld(pc_ld), .pc_br(pc_br), .addr_sel(addr_sel),
    .alu_src_imm(alu_src_imm), .ext_sign(ext_sign), .alu_op(alu_op), .wb_sel(wb_sel),
    .dst_rd(dst_rd), .st_en(st_en), .opcode(opcode), .equal(equal), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  localparam int NV = 16;
  localparam logic [68:0] VEC [NV] = '{
    {enc_i(13, 0, 1, 16'h1234), 5'd1,  32'h0000_1234},
    {enc_i(13, 0, 2, 16'hFFFF), 5'd2,  32'h0000_FFFF},
    {enc_r(1, 2, 3, 6'h20),     5'd3,  32'h0001_1233},
    {enc_r(1, 2, 4, 6'h22),     5'd4,  32'hFFFF_1235},
    {enc_r(1, 2, 5, 6'h24),     5'd5,  32'h0000_1234},
    {enc_r(4, 1, 6, 6'h25),     5'd6,  32'hFFFF_1235},
    {enc_r(4, 1, 7, 6'h2A),     5'd7,  32'h0000_0001},
    {enc_i(43, 0, 3, 16'h0200), 5'd3,  32'h0001_1233},
    {enc_i(35, 0, 8, 16'h0200), 5'd8,  32'h0001_1233},
    {enc_i(13, 1, 0, 16'h00FF), 5'd0,  32'h0000_0000},
    {enc_i(13, 0, 10, 16'h0208), 5'd10, 32'h0000_0208},
    {enc_i(35, 10, 9, 16'hFFF8), 5'd9,  32'h0001_1233},
    {enc_r(1, 2, 0, 6'h20),     5'd0,  32'h0000_0000},
    {enc_r(1, 4, 11, 6'h2A),    5'd11, 32'h0000_0000},
    {enc_r(1, 2, 12, 6'h23),    5'd12, 32'hFFFF_1235},
    {enc_r(1, 2, 13, 6'h00),    5'd13, 32'h0001_1233}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic clr();
    {ir_ld, ab_ld, s_ld, m_ld, rf_wr, pc_ld, pc_br, addr_sel, alu_src_imm, ext_sign, wb_sel, dst_rd, st_en} = '0;
    alu_op = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); clr();
  endtask

  task automatic fetch_decode(logic [31:0] ins);
    mem[exp_pc[9:2]] = ins;
    ir_ld = 1'b1; tick();
    ab_ld = 1'b1; tick();
  endtask

  task automatic probe(int r, output logic [31:0] v);
    fetch_decode(enc_r(r, r, 0, 6'h20));
    v = mem_wdata;
  endtask

  task automatic exec(logic [31:0] ins);
    fetch_decode(ins);
    case (ins[31:26])
      6'h00: begin
        s_ld = 1'b1; alu_op = 2'b11; tick();
        rf_wr = 1'b1; dst_rd = 1'b1; pc_ld = 1'b1; tick();
      end
      6'h0D: begin
        s_ld = 1'b1; alu_src_imm = 1'b1; alu_op = 2'b10; tick();
        rf_wr = 1'b1; pc_ld = 1'b1; tick();
      end
      6'h23: begin
        s_ld = 1'b1; alu_src_imm = 1'b1; ext_sign = 1'b1; tick();
        addr_sel = 1'b1; m_ld = 1'b1; tick();
        rf_wr = 1'b1; wb_sel = 1'b1; pc_ld = 1'b1; tick();
      end
      6'h2B: begin
        s_ld = 1'b1; alu_src_imm = 1'b1; ext_sign = 1'b1; tick();
        addr_sel = 1'b1; st_en = 1'b1; #1;
        chk("R7 store address", {2'b00, mem_addr}, 32'd128);
        pc_ld = 1'b1; tick();
      end
      default: begin
        pc_br = equal; pc_ld = 1'b1; tick();
      end
    endcase
    exp_pc = exp_pc + 4;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pc", {2'b00, mem_addr}, 32'd0);
    chk("R1 reset equal", {31'd0, equal}, 32'd1);
    probe(5, v);
    chk("R1 reset regfile", v, 32'd0);

    for (int i = 0; i < NV; i++) begin
      exec(VEC[i][68:37]);
      probe(int'(VEC[i][36:32]), v);
      chk($sformatf("R3 R4 R5 R6 R10 vector %0d", i), v, VEC[i][31:0]);
    end
    chk("R7 stored word", mem[128], 32'h0001_1233);
    chk("R2 R9 pc after sequence", {2'b00, mem_addr}, exp_pc >> 2);

    repeat (3) tick();
    chk("R9 pc holds when idle", {2'b00, mem_addr}, exp_pc >> 2);

    fetch_decode(enc_i(4, 1, 1, 16'h0003));
    chk("R8 equal high", {31'd0, equal}, 32'd1);
    chk("R2 opcode out", {26'd0, opcode}, 32'd4);
    pc_br = equal; pc_ld = 1'b1; tick();
    exp_pc = exp_pc + 4 + 12;
    chk("R9 taken forward branch", {2'b00, mem_addr}, exp_pc >> 2);

    fetch_decode(enc_i(4, 1, 2, 16'h0003));
    chk("R8 equal low", {31'd0, equal}, 32'd0);
    pc_br = equal; pc_ld = 1'b1; tick();
    exp_pc = exp_pc + 4;
    chk("R9 untaken branch", {2'b00, mem_addr}, exp_pc >> 2);

    fetch_decode(enc_i(4, 0, 0, 16'hFFFE));
    pc_br = equal; pc_ld = 1'b1; tick();
    exp_pc = exp_pc - 4;
    chk("R9 backward branch", {2'b00, mem_addr}, exp_pc >> 2);

    s_ld = 1'b1; alu_op = 2'b01; tick();
    addr_sel = 1'b1; #1;
    chk("R4 subtract op equal operands", {2'b00, mem_addr}, 32'd0);
    clr();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule